// File: doc/BRIEF.md
# Power-On and Warm Reset Sequencer

This block sits between an active-low external reset pin and the rest of a device. It decides whether each reset is a power-on reset or a warm reset, rejects pulses that are too short for the current kind, and keeps a ready output low through a recovery wait after reset is released. While the device is not ready, it forces the microcontroller I/O into input mode and disables the address output drivers.

The first qualifying reset after the supply-steady input rises is a power-on reset. It needs `POR_W` consecutive low samples. Later resets are warm resets and need only `WARM_W` low samples, until the supply-steady input drops again. When a reset qualifies, the block sends one-cycle clear strobes to the register classes it affects. It also reloads a local configuration register from a default with two bits forced to zero.

Separately, write strobes and configuration writes are blocked while the supply sits below the write-lockout level. Both the supply-steady and the lockout indications arrive as digital inputs, and all widths are counted in clock cycles.

Top module: `rst_seq`

## Requirements
- R1: While `pwr_ok_i` is low, and after it rises until a power-on reset has qualified and recovered, `ready_o` is 0 and all clear strobes are 0.
- R2: With no qualified reset yet since the supply became steady, a reset pulse qualifies when `rst_n_i` is sampled low on `POR_W` consecutive clock edges. A shorter pulse is ignored: no strobe fires and `ready_o` stays 0.
- R3: Once running, a reset qualifies as warm after `WARM_W` consecutive low samples. A shorter pulse is ignored: `ready_o` stays 1 and no strobe fires.
- R4: A qualified reset drives `ready_o` to 0 at the qualifying edge. After the first edge that samples `rst_n_i` high, `ready_o` rises exactly `REC_W` edges later.
- R5: On a power-on reset, `clr_mode_o`, `clr_gen_o` and `mc_clr_o` are all 1 for exactly the one cycle that follows the qualifying edge.
- R6: On a warm reset, only `clr_gen_o` pulses for one cycle. `clr_mode_o` and `mc_clr_o` stay 0, so the mode registers keep their value and the logic-array flops follow their own set/reset inputs.
- R7: On either kind of reset, `cfg_o` reloads to `CFG_DEF` with bits `ZB0` and `ZB1` cleared. With the default parameters this gives 8'h81.
- R8: Whenever `ready_o` is 0, `io_in_o` is 1 (I/O in input mode) and `addr_oe_o` is 0 (address outputs tri-stated). When `ready_o` is 1, these are 0 and 1.
- R9: While `lko_ok_i` is 0, `wr_n_o` is held at 1 whatever `wr_n_i` is, and `cfg_we_i` has no effect on `cfg_o`. While `lko_ok_i` is 1, `wr_n_o` follows `wr_n_i`, and a write loads `cfg_wd_i` into `cfg_o` on the next edge.
- R10: A low sample of `rst_n_i` during the recovery wait restarts the sequence. The strobes of the same reset kind fire again, and the full `REC_W` wait starts again after the next release.
- R11: A drop of `pwr_ok_i` returns the block to the power-on state. The next reset then needs `POR_W` low samples and is treated as power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok_i | input | 1 | Supply steady; low clears the block asynchronously |
| lko_ok_i | input | 1 | Supply above the write-lockout level |
| rst_n_i | input | 1 | External reset, active low |
| wr_n_i | input | 1 | Write strobe in, active low |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_wd_i | input | CFG_W | Configuration register write data |
| wr_n_o | output | 1 | Gated write strobe, active low |
| ready_o | output | 1 | Device ready for memory access |
| io_in_o | output | 1 | Force microcontroller I/O into input mode |
| addr_oe_o | output | 1 | Address output enable (0 = tri-stated) |
| clr_mode_o | output | 1 | Clear strobe for mode registers (power-on only) |
| clr_gen_o | output | 1 | Clear strobe for general registers (both kinds) |
| mc_clr_o | output | 1 | Clear strobe for logic-array flops (power-on only) |
| cfg_o | output | CFG_W | Configuration register value |

## Verification
On every cycle, the assertions check the following:
- `ready_o` falls only together with a clear strobe.
- `ready_o` rises only after `rst_n_i` has been sampled high.
- A strobe never arrives while the device is ready.
- A power-on-class strobe never follows a ready cycle.
- The configuration register does not move under write lockout unless a reset reloads it.

The bench has to show the rest. It sweeps pulse lengths around each minimum width to find the exact qualification threshold and counts the recovery wait edge by edge. It also covers a restart during recovery and checks that a supply drop makes the next reset power-on again.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int POR_W = 1000,
  parameter int WARM_W = 20,
  parameter int REC_W = 200,
  parameter int CFG_W = 8,
  parameter logic [CFG_W-1:0] CFG_DEF = 8'hA5,
  parameter int ZB0 = 2,
  parameter int ZB1 = 5
) (
  input  logic             clk,
  input  logic             pwr_ok_i,
  input  logic             lko_ok_i,
  input  logic             rst_n_i,
  input  logic             wr_n_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wd_i,
  output logic             wr_n_o,
  output logic             ready_o,
  output logic             io_in_o,
  output logic             addr_oe_o,
  output logic             clr_mode_o,
  output logic             clr_gen_o,
  output logic             mc_clr_o,
  output logic [CFG_W-1:0] cfg_o
);

  localparam int MAXW = (POR_W > WARM_W) ? ((POR_W > REC_W) ? POR_W : REC_W)
                                         : ((WARM_W > REC_W) ? WARM_W : REC_W);
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [CFG_W-1:0] ZMASK = (CFG_W'(1) << ZB0) | (CFG_W'(1) << ZB1);
  localparam logic [CFG_W-1:0] CFG_RST = CFG_DEF & ~ZMASK;
  localparam logic [CW-1:0] POR_LAST = CW'(POR_W - 1);
  localparam logic [CW-1:0] WARM_LAST = CW'(WARM_W - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_W - 1);

  typedef enum logic [1:0] {S_WAIT, S_RUN, S_HOLD, S_REC} st_t;

  st_t             st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            por_q, por_d;
  logic            pulse_q;
  logic            qual;
  logic [CFG_W-1:0] cfg_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    por_d = por_q;
    qual  = 1'b0;
    case (st_q)
      S_WAIT: begin
        if (rst_n_i) cnt_d = '0;
        else if (cnt_q == POR_LAST) begin
          qual = 1'b1; por_d = 1'b1; st_d = S_HOLD; cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_RUN: begin
        if (rst_n_i) cnt_d = '0;
        else if (cnt_q == WARM_LAST) begin
          qual = 1'b1; por_d = 1'b0; st_d = S_HOLD; cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      S_HOLD: begin
        cnt_d = '0;
        if (rst_n_i) st_d = S_REC;
      end
      default: begin
        if (!rst_n_i) begin
          qual = 1'b1; st_d = S_HOLD; cnt_d = '0;
        end else if (cnt_q == REC_LAST) begin
          st_d = S_RUN; cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge pwr_ok_i) begin
    if (!pwr_ok_i) begin
      st_q    <= S_WAIT;
      cnt_q   <= '0;
      por_q   <= 1'b1;
      pulse_q <= 1'b0;
      cfg_q   <= CFG_RST;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      por_q   <= por_d;
      pulse_q <= qual;
      if (qual) cfg_q <= CFG_RST;
      else if (cfg_we_i && lko_ok_i) cfg_q <= cfg_wd_i;
    end
  end

  assign ready_o    = (st_q == S_RUN);
  assign io_in_o    = !ready_o;
  assign addr_oe_o  = ready_o;
  assign clr_gen_o  = pulse_q;
  assign clr_mode_o = pulse_q & por_q;
  assign mc_clr_o   = pulse_q & por_q;
  assign cfg_o      = cfg_q;
  assign wr_n_o     = wr_n_i | !lko_ok_i;

  // R4
  ready_fall_chk: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    $fell(ready_o) |-> clr_gen_o);

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    $rose(ready_o) |-> $past(rst_n_i));

  // R5
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    clr_gen_o |-> !ready_o);

  // R6
  warm_class_chk: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    $past(ready_o) |-> !clr_mode_o && !mc_clr_o);

  // R9
  lockout_cfg_chk: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    !lko_ok_i |=> ($stable(cfg_o) || clr_gen_o));

endmodule

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam int CLK_P = 10;
  localparam int POR = 6;
  localparam int WARM = 3;
  localparam int REC = 4;
  localparam logic [7:0] DEF = 8'hA5;
  localparam logic [7:0] RLD = DEF & ~(8'h04 | 8'h20);

  logic clk = 0;
  logic pwr_ok = 0, lko_ok = 1, rst_n = 1, wr_n = 1, cfg_we = 0;
  logic [7:0] cfg_wd = 0;
  logic wr_n_o, ready, io_in, addr_oe, clr_mode, clr_gen, mc_clr;
  logic [7:0] cfg;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_seq #(.POR_W(POR), .WARM_W(WARM), .REC_W(REC), .CFG_W(8), .CFG_DEF(DEF),
            .ZB0(2), .ZB1(5)) uut (
    .clk(clk), .pwr_ok_i(pwr_ok), .lko_ok_i(lko_ok), .rst_n_i(rst_n),
    .wr_n_i(wr_n), .cfg_we_i(cfg_we), .cfg_wd_i(cfg_wd), .wr_n_o(wr_n_o),
    .ready_o(ready), .io_in_o(io_in), .addr_oe_o(addr_oe), .clr_mode_o(clr_mode),
    .clr_gen_o(clr_gen), .mc_clr_o(mc_clr), .cfg_o(cfg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic power_up();
    pwr_ok = 0; rst_n = 1; #1;
    step(); step();
    pwr_ok = 1;
    step();
  endtask

  task automatic release_and_recover(input string req);
    rst_n = 1;
    step();
    chk(req, {29'd0, clr_gen, clr_mode, mc_clr}, 0);
    repeat (REC - 1) step();
    chk(req, ready, 0);
    step();
    chk(req, {30'd0, ready, addr_oe}, 32'b11);
    chk("R8", io_in, 0);
  endtask

  task automatic full_por();
    rst_n = 0;
    repeat (POR) step();
    chk("R5", {29'd0, clr_mode, clr_gen, mc_clr}, 32'b111);
    chk("R7", cfg, RLD);
    release_and_recover("R4");
  endtask

  initial begin
    #1;
    chk("R1", ready, 0);
    chk("R8", {30'd0, io_in, addr_oe}, 32'b10);
    // R2 sweep of short power-on pulses
    for (int n = 1; n < POR; n++) begin
      power_up();
      rst_n = 0;
      for (int i = 0; i < n; i++) begin
        step();
        chk("R2", clr_gen, 0);
      end
      rst_n = 1;
      repeat (REC + 2) step();
      chk("R2", ready, 0);
      chk("R1", clr_mode, 0);
    end
    // R2 pulses at and beyond the threshold
    for (int n = POR; n <= POR + 2; n++) begin
      power_up();
      rst_n = 0;
      for (int i = 1; i <= n; i++) begin
        step();
        chk("R2", clr_gen, (i == POR));
        chk("R8", io_in, 1);
      end
      release_and_recover("R4");
    end
    // R3 warm sweep
    for (int n = 1; n <= WARM + 2; n++) begin
      cfg_we = 1; cfg_wd = 8'hFF; step(); cfg_we = 0;
      chk("R9", cfg, 8'hFF);
      rst_n = 0;
      for (int i = 1; i <= n; i++) begin
        step();
        chk("R3", ready, (i < WARM));
        chk("R6", {30'd0, clr_gen, clr_mode | mc_clr}, (i == WARM) ? 32'b10 : 32'b00);
      end
      if (n >= WARM) begin
        chk("R7", cfg, RLD);
        release_and_recover("R4");
      end else begin
        rst_n = 1; step();
        chk("R3", ready, 1);
        chk("R3", cfg, 8'hFF);
      end
    end
    // R9 lockout
    lko_ok = 0; wr_n = 0; #1;
    chk("R9", wr_n_o, 1);
    cfg_we = 1; cfg_wd = 8'h3C; step(); cfg_we = 0;
    chk("R9", cfg, RLD);
    lko_ok = 1; #1;
    chk("R9", wr_n_o, 0);
    wr_n = 1; #1;
    chk("R9", wr_n_o, 1);
    cfg_we = 1; step(); cfg_we = 0;
    chk("R9", cfg, 8'h3C);
    // R10 restart during recovery (warm kind)
    rst_n = 0; repeat (WARM) step();
    rst_n = 1; step(); step();
    rst_n = 0; step();
    chk("R10", {30'd0, clr_gen, clr_mode}, 32'b10);
    chk("R10", ready, 0);
    release_and_recover("R10");
    // R10 restart during power-on recovery keeps power-on kind
    power_up();
    rst_n = 0; repeat (POR) step();
    rst_n = 1; step();
    rst_n = 0; step();
    chk("R10", {29'd0, clr_gen, clr_mode, mc_clr}, 32'b111);
    release_and_recover("R10");
    // R11 supply drop returns to power-on rules
    pwr_ok = 0; #1;
    chk("R1", ready, 0);
    pwr_ok = 1;
    rst_n = 0;
    for (int i = 1; i <= POR; i++) begin
      step();
      chk("R11", clr_gen, (i == POR));
    end
    chk("R11", clr_mode, 1);
    release_and_recover("R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule